// File: doc/BRIEF.md
# Decode-Stage Branch Resolver

This block settles conditional branches while the branch is still in the decode stage of a five-stage in-order pipeline. It compares the two branch operands, which have already passed through decode-stage forwarding. A dedicated adder forms the taken target in the same cycle. The block also owns the fetch program counter and chooses its next value. Because the decision is made in decode, a taken branch costs one fetch cycle instead of three. That one cycle is visible to software as a delay slot: the instruction fetched while the branch sits in decode always executes, whether or not the branch is taken.

The decode slot is offered as a stream. `dec_valid` marks that an instruction is present, and `dec_ready` low is back-pressure. While ready is low, the upstream stage must hold every decode input unchanged, and the fetch counter does not move. Ready drops for exactly one reason. A valid branch in decode reads a nonzero register that the instruction now in execute will write, so its operand cannot be forwarded yet. The execute-stage write information enters as plain control pins. With valid low, or with a non-branch in decode, the fetch counter simply steps by four.

Top module: `branch_resolver`

## Requirements
- R1: While reset is held, and in the first cycle after it, `fetch_pc` equals the parameter RESET_PC (default 0), and both `br_taken` and `dec_slot` are 0.
- R2: A valid, accepted branch with `dec_ne` = 0 (equal test) raises `br_taken` in the same cycle if and only if `dec_rs_val` equals `dec_rt_val`.
- R3: A valid, accepted branch with `dec_ne` = 1 (not-equal test) raises `br_taken` in the same cycle if and only if `dec_rs_val` differs from `dec_rt_val`.
- R4: In a cycle where `dec_ready` is 1 and `br_taken` is 0, `fetch_pc` becomes `fetch_pc + 4` at the next clock edge. When `br_taken` is 1, `fetch_pc` becomes the target at the very next edge. The instruction fetched during the branch's decode cycle is therefore the only slot instruction.
- R5: `dec_ready` is 0 exactly when a valid branch is in decode, `ex_wr_en` is 1, `ex_wr_reg` is nonzero, and `ex_wr_reg` matches `dec_rs` or `dec_rt`. In that cycle `br_taken` is 0 and `fetch_pc` holds.
- R6: The target is `dec_pc4` plus the 16-bit `dec_off`, sign-extended and shifted left by two. Negative offsets reach backward. `next_pc` shows the target when taken, and otherwise shows `fetch_pc + 4`.
- R7: `dec_slot` is 1 in the cycle after a valid branch is accepted, and 0 after any other accepted cycle. This holds even when the slot instruction is itself a branch, in which case that branch's slot is the first instruction at the outer target.
- R8: With `dec_valid` 0, or `dec_br` 0, `br_taken` is 0 and `dec_ready` is 1, whatever the operand and register inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | An instruction occupies decode |
| dec_ready | output | 1 | Decode may advance this cycle; 0 is a one-cycle stall |
| dec_br | input | 1 | The decode instruction is a conditional branch |
| dec_ne | input | 1 | Condition: 0 = taken on equal, 1 = taken on not-equal |
| dec_rs | input | 5 | First source register number |
| dec_rt | input | 5 | Second source register number |
| dec_rs_val | input | 32 | First operand after forwarding |
| dec_rt_val | input | 32 | Second operand after forwarding |
| dec_off | input | 16 | Branch offset in words, two's complement |
| dec_pc4 | input | 32 | Address of the branch plus 4 |
| ex_wr_en | input | 1 | The instruction in execute writes a register |
| ex_wr_reg | input | 5 | Register written by the instruction in execute |
| br_taken | output | 1 | The branch in decode is taken this cycle |
| next_pc | output | 32 | Value `fetch_pc` takes at the next accepted edge |
| fetch_pc | output | 32 | Address being fetched this cycle |
| dec_slot | output | 1 | The instruction now in decode is a delay slot |

## Verification
The bench fetches a short program that loops. Along the way it meets each of these cases:
- a taken equal branch, and a taken not-equal branch; these separate the two condition senses;
- an equal test and a not-equal test that are both not taken; these show that a false condition leaves the counter stepping;
- a not-equal branch that depends on the instruction just ahead of it; this exercises the one-cycle stall and shows that the decision is held until the operand is ready;
- a branch that reads a register the instruction in execute writes as register zero; this shows that register zero never stalls;
- a branch placed in the slot of a taken branch; this shows that the inner branch's slot is the outer target;
- a backward loop branch with a negative offset; this separates sign extension from zero extension.

The reset cycle, where decode is empty, checks that an invalid slot has no effect.

// File: rtl/br_pkg.sv
package br_pkg;
  typedef enum logic {
    COND_EQ = 1'b0,
    COND_NE = 1'b1
  } br_cond_e;

  localparam int unsigned INSTR_BYTES = 4;
  localparam int unsigned WORD_SHIFT  = 2;
endpackage

// File: rtl/br_compare.sv
module br_compare
  import br_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  br_cond_e     cond,
  output logic         hit
);
  logic same;

  always_comb begin
    same = (op_a == op_b);
    unique case (cond)
      COND_EQ: hit = same;
      COND_NE: hit = !same;
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/br_target.sv
module br_target
  import br_pkg::*;
#(
  parameter int unsigned W     = 32,
  parameter int unsigned OFF_W = 16
) (
  input  logic [W-1:0]     pc4,
  input  logic [OFF_W-1:0] off,
  output logic [W-1:0]     target
);
  localparam int unsigned EXT_W = W - OFF_W - WORD_SHIFT;

  logic [W-1:0] byte_off;

  always_comb begin
    byte_off = {{EXT_W{off[OFF_W-1]}}, off, {WORD_SHIFT{1'b0}}};
    target   = pc4 + byte_off;
  end
endmodule

// File: rtl/br_hazard.sv
module br_hazard #(
  parameter int unsigned AW = 5
) (
  input  logic          is_branch,
  input  logic [AW-1:0] src_a,
  input  logic [AW-1:0] src_b,
  input  logic          ex_en,
  input  logic [AW-1:0] ex_reg,
  output logic          stall
);
  localparam int unsigned NSRC = 2;

  logic [NSRC-1:0][AW-1:0] srcs;
  logic [NSRC-1:0]         match;
  logic                    ex_live;

  assign srcs[0] = src_a;
  assign srcs[1] = src_b;
  assign ex_live = ex_en && (ex_reg != '0);

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign match[g] = ex_live && (srcs[g] == ex_reg);
  end

  assign stall = is_branch && (|match);
endmodule

// File: rtl/branch_resolver.sv
module branch_resolver
  import br_pkg::*;
#(
  parameter int unsigned        XLEN     = 32,
  parameter int unsigned        OFF_W    = 16,
  parameter int unsigned        REG_AW   = 5,
  parameter logic [XLEN-1:0]    RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dec_valid,
  output logic              dec_ready,
  input  logic              dec_br,
  input  logic              dec_ne,
  input  logic [REG_AW-1:0] dec_rs,
  input  logic [REG_AW-1:0] dec_rt,
  input  logic [XLEN-1:0]   dec_rs_val,
  input  logic [XLEN-1:0]   dec_rt_val,
  input  logic [OFF_W-1:0]  dec_off,
  input  logic [XLEN-1:0]   dec_pc4,
  input  logic              ex_wr_en,
  input  logic [REG_AW-1:0] ex_wr_reg,
  output logic              br_taken,
  output logic [XLEN-1:0]   next_pc,
  output logic [XLEN-1:0]   fetch_pc,
  output logic              dec_slot
);
  localparam logic [XLEN-1:0] STEP = XLEN'(INSTR_BYTES);

  logic            live_br;
  logic            cond_hit;
  logic            stall;
  logic [XLEN-1:0] target;
  br_cond_e        cond;

  assign live_br = dec_valid && dec_br;
  assign cond    = br_cond_e'(dec_ne);

  br_compare #(.W(XLEN)) u_cmp (
    .op_a (dec_rs_val),
    .op_b (dec_rt_val),
    .cond (cond),
    .hit  (cond_hit)
  );

  br_target #(.W(XLEN), .OFF_W(OFF_W)) u_tgt (
    .pc4    (dec_pc4),
    .off    (dec_off),
    .target (target)
  );

  br_hazard #(.AW(REG_AW)) u_haz (
    .is_branch (live_br),
    .src_a     (dec_rs),
    .src_b     (dec_rt),
    .ex_en     (ex_wr_en),
    .ex_reg    (ex_wr_reg),
    .stall     (stall)
  );

  assign dec_ready = !stall;
  assign br_taken  = live_br && !stall && cond_hit;
  assign next_pc   = br_taken ? target : fetch_pc + STEP;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fetch_pc <= RESET_PC;
      dec_slot <= 1'b0;
    end else if (dec_ready) begin
      fetch_pc <= next_pc;
      dec_slot <= live_br;
    end
  end
endmodule

// File: rtl/branch_resolver_chk.sv
module branch_resolver_chk #(
  parameter int unsigned     XLEN     = 32,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input logic            clk,
  input logic            rst_n,
  input logic            dec_valid,
  input logic            dec_br,
  input logic            dec_ready,
  input logic            br_taken,
  input logic [XLEN-1:0] next_pc,
  input logic [XLEN-1:0] fetch_pc,
  input logic            dec_slot
);
  p_reset_pc_r1: assert property (@(posedge clk)
    !rst_n |=> (fetch_pc == RESET_PC) && !dec_slot);

  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_ready && !br_taken) |=> fetch_pc == $past(fetch_pc) + 32'd4);

  p_redirect_r6: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken |=> fetch_pc == $past(next_pc));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_ready |=> $stable(fetch_pc));

  p_no_take_stalled_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_ready |-> !br_taken);

  p_slot_after_branch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_ready && dec_valid && dec_br) |=> dec_slot);

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(dec_valid && dec_br) |-> (dec_ready && !br_taken));
endmodule

bind branch_resolver branch_resolver_chk #(.XLEN(XLEN), .RESET_PC(RESET_PC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .dec_valid (dec_valid),
  .dec_br    (dec_br),
  .dec_ready (dec_ready),
  .br_taken  (br_taken),
  .next_pc   (next_pc),
  .fetch_pc  (fetch_pc),
  .dec_slot  (dec_slot)
);

// File: tb/test_branch_resolver.sv
module test_branch_resolver;
  localparam int CLK_PERIOD = 10;
  localparam int RUN_CYCLES = 80;
  localparam int WATCHDOG   = 5000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dec_valid = 1'b0, dec_br = 1'b0, dec_ne = 1'b0;
  logic [4:0]  dec_rs = '0, dec_rt = '0, ex_wr_reg = '0;
  logic [31:0] dec_rs_val = '0, dec_rt_val = '0, dec_pc4 = '0;
  logic [15:0] dec_off = '0;
  logic        ex_wr_en = 1'b0;
  logic        dec_ready, br_taken, dec_slot;
  logic [31:0] next_pc, fetch_pc;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  branch_resolver i_branch_resolver (
    .clk, .rst_n, .dec_valid, .dec_ready, .dec_br, .dec_ne,
    .dec_rs, .dec_rt, .dec_rs_val, .dec_rt_val, .dec_off, .dec_pc4,
    .ex_wr_en, .ex_wr_reg, .br_taken, .next_pc, .fetch_pc, .dec_slot
  );

  // program: kind 0 = nop, 1 = alu writing rd, 2 = beq, 3 = bne
  int          p_kind [64];
  logic [4:0]  p_rs [64], p_rt [64], p_rd [64];
  logic [15:0] p_off [64];
  logic [31:0] regs [32];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic put(input int w, input int k, input int rs, input int rt,
                     input int rd, input int off);
    p_kind[w] = k;
    p_rs[w] = 5'(rs); p_rt[w] = 5'(rt); p_rd[w] = 5'(rd);
    p_off[w] = 16'(off);
  endtask

  // reference state
  logic        m_dv, m_br, m_ne, m_wr, m_exw, m_slot;
  logic [4:0]  m_rs, m_rt, m_rd, m_exr;
  logic [15:0] m_off;
  logic [31:0] m_pc, m_pc4;

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) put(i, 0, 0, 0, 0, 0);
    for (int i = 0; i < 32; i++) regs[i] = 32'h100 + 32'(i);
    regs[0] = 0; regs[2] = 0; regs[3] = 0; regs[1] = 7; regs[8] = 9;
    regs[5] = 3; regs[6] = 4;
    put(0, 1, 0, 0, 1, 0);     // alu r1
    put(1, 2, 2, 3, 0, 3);     // beq taken -> word 5
    put(2, 1, 0, 0, 0, 0);     // slot: alu writing r0
    put(5, 3, 0, 2, 0, 9);     // bne r0,r2 not taken, r0 never stalls
    put(6, 1, 0, 0, 5, 0);     // alu r5
    put(7, 3, 5, 6, 0, 4);     // bne stalls one cycle, then taken -> 12
    put(8, 2, 2, 3, 0, 10);    // branch in slot, taken -> 19
    put(12, 1, 0, 0, 7, 0);    // slot of inner branch
    put(19, 2, 1, 8, 0, 5);    // beq not taken
    put(20, 2, 0, 0, 0, -21);  // backward loop -> 0
    put(21, 0, 0, 0, 0, 0);

    m_dv = 0; m_br = 0; m_ne = 0; m_wr = 0; m_exw = 0; m_slot = 0;
    m_rs = 0; m_rt = 0; m_rd = 0; m_exr = 0; m_off = 0; m_pc = 0; m_pc4 = 0;

    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1 fetch_pc in reset", fetch_pc, 32'h0);
    chk("R1 dec_slot in reset", {31'b0, dec_slot}, 32'h0);
    @(posedge clk);
    #1 rst_n = 1'b1;

    for (int cyc = 0; cyc < RUN_CYCLES; cyc++) begin
      logic        stall_m, cond_m, take_m;
      logic [31:0] so, nxt;
      int          idx;
      @(negedge clk);
      chk(cyc == 0 ? "R1 fetch_pc after reset" : "R4 fetch_pc sequence", fetch_pc, m_pc);
      chk("R7 dec_slot", {31'b0, dec_slot}, {31'b0, m_slot});
      dec_valid = m_dv; dec_br = m_br; dec_ne = m_ne;
      dec_rs = m_rs; dec_rt = m_rt;
      dec_rs_val = regs[m_rs]; dec_rt_val = regs[m_rt];
      dec_off = m_off; dec_pc4 = m_pc4;
      ex_wr_en = m_exw; ex_wr_reg = m_exr;
      stall_m = m_dv && m_br && m_exw && (m_exr != 0) && (m_exr == m_rs || m_exr == m_rt);
      cond_m  = m_ne ? (regs[m_rs] != regs[m_rt]) : (regs[m_rs] == regs[m_rt]);
      take_m  = m_dv && m_br && !stall_m && cond_m;
      so  = {{16{m_off[15]}}, m_off};
      nxt = take_m ? m_pc4 + (so << 2) : m_pc + 32'd4;
      #1;
      chk(m_br && m_dv ? "R5 dec_ready" : "R8 dec_ready idle", {31'b0, dec_ready}, {31'b0, !stall_m});
      if (!(m_dv && m_br)) chk("R8 br_taken idle", {31'b0, br_taken}, 32'h0);
      else if (m_ne) chk("R3 br_taken bne", {31'b0, br_taken}, {31'b0, take_m});
      else chk("R2 br_taken beq", {31'b0, br_taken}, {31'b0, take_m});
      if (take_m) chk("R6 next_pc target", next_pc, nxt);
      else if (!stall_m) chk("R4 next_pc step", next_pc, nxt);
      if (stall_m) begin
        m_exw = 0;
      end else begin
        m_exw  = m_dv && m_wr;
        m_exr  = m_rd;
        m_slot = m_dv && m_br;
        idx    = int'(m_pc[7:2]);
        m_dv   = 1;
        m_br   = (p_kind[idx] >= 2);
        m_ne   = (p_kind[idx] == 3);
        m_wr   = (p_kind[idx] == 1);
        m_rs   = p_rs[idx]; m_rt = p_rt[idx]; m_rd = p_rd[idx];
        m_off  = p_off[idx];
        m_pc4  = m_pc + 32'd4;
        m_pc   = nxt;
      end
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule